// File: doc/BRIEF.md
# Host-to-PCI Address Window Translator

This block sits between a host-side request port and a PCI-side request engine. It watches every host read or write. A request whose address falls in the fixed 1 GB window at host addresses 0x8000_0000 to 0xBFFF_FFFF is turned into a single PCI-side request descriptor. The descriptor holds a command, a 32-bit bus address, byte enables and write data. The block then waits for the PCI side to answer and completes the host request. Requests outside the window, and requests that cannot legally become a bus cycle, complete at once with no bus activity.

A small control register sets three things. One bit switches the whole window between memory cycles and configuration cycles. A 2-bit field supplies the two upper bus address bits. A 2-bit field sets how the bus reset pin is driven. In configuration mode the low host address bits already carry the bus layout: the one-hot device select at bit 13 plus the device number, the function number in bits 10:8 and the dword register in bits 7:2. The window is cut to its first 1 MB in this mode. When the PCI side aborts a transfer, a read returns all ones and a one-cycle abort event goes to the interrupt logic.

Top module: `pci_win_xlat`

## Requirements
- R1: Only host addresses with bits 31:30 equal to 2'b10 can produce a bus request. Any other request completes with `h_done` and `h_skip` high, `h_rdata` = 0xFFFFFFFF and no `p_req_valid`.
- R2: The bus address takes its bits 29:0 from the host address and its bits 31:30 from control field `ctl[3:2]`.
- R3: Control bit `ctl[1]` = 0 gives memory commands and 1 gives configuration commands. `p_cmd` codes are 0 memory read, 1 memory write, 2 configuration read and 3 configuration write. No other command is ever issued.
- R4: In configuration mode, a window request with any of host address bits 29:20 set produces no bus request and completes with `h_skip` high.
- R5: `h_size` 0, 1 and 2 mean 1, 2 and 4 bytes. `p_be[i]` is set for each byte lane i covered from lane `h_addr[1:0]`. Size 3, or an address not aligned to the size, produces no bus request and completes with `h_skip` high.
- R6: A bus read that is not aborted returns `p_rsp_data` on `h_rdata` when `h_done` is high, with `h_skip` low. `p_wdata` carries the accepted `h_wdata`.
- R7: An aborted response completes the host request with `h_rdata` = 0xFFFFFFFF and pulses `irq_abort` for exactly the cycle in which `h_done` is high.
- R8: Reset pin mode `ctl[5:4]`: 00 releases the pin (`rst_pin_oe`=0), 01 drives it low, 10 drives it high, and 11 acts like 00.
- R9: After reset `ctl_q` is 0, the pin is released, `h_ready` is 1 and `p_req_valid` is 0.
- R10: While `p_req_valid` is high and `p_req_ready` is low, the descriptor stays unchanged. `h_ready` is low from acceptance until completion.
- R11: The control settings are sampled when a request is accepted. A control write made while the request is in flight does not change its descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Control write value (bit 1 cycle select, 3:2 upper address, 5:4 pin mode) |
| ctl_q | output | 6 | Current control register value |
| rst_pin_oe | output | 1 | Bus reset pin output enable |
| rst_pin_out | output | 1 | Bus reset pin driven level |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Block can accept a host request |
| h_write | input | 1 | Host request is a write |
| h_addr | input | 32 | Host byte address |
| h_size | input | 2 | Transfer size code |
| h_wdata | input | 32 | Host write data, lane positioned |
| h_done | output | 1 | One-cycle completion strobe |
| h_skip | output | 1 | Completion produced no bus cycle |
| h_rdata | output | 32 | Completion read data |
| p_req_valid | output | 1 | Bus request descriptor valid |
| p_req_ready | input | 1 | Bus engine accepts the descriptor |
| p_cmd | output | 2 | Bus command code |
| p_addr | output | 32 | Bus address |
| p_be | output | 4 | Byte enables |
| p_wdata | output | 32 | Bus write data |
| p_rsp_valid | input | 1 | Bus response valid |
| p_rsp_abort | input | 1 | Bus response reports an abort |
| p_rsp_data | input | 32 | Bus response read data |
| irq_abort | output | 1 | One-cycle abort event to the interrupt logic |

## Verification
The bench goes after the window edges 0x7FFF_FFFC, 0x8000_0000, 0xBFFF_FFFC and 0xC000_0000. A decoder that compares one bit too few would start bus cycles outside the window or drop them inside it. It probes the configuration limit just below and at 1 MB, where a wrong limit would let an access through to a device select outside the mapped region. It also covers every size and alignment pairing, so a wrong lane shift or a missed misalignment shows up as wrong `p_be` or a spurious cycle. An abort on a write and on a read, a stalled request engine, reset pin code 11, and a control write made while a request is pending round it off. Each of these would catch a lost pulse, garbage read data, a descriptor that shifts under back-pressure, a driven reserved mode, or settings picked up late.

// File: rtl/pwx_pkg.sv
// Package: shared widths, command codes and state encoding for the
// host-to-PCI window translator. Assumes a 32-bit bus with 4 byte lanes.
package pwx_pkg;

    parameter int PWX_AW  = 32;
    parameter int PWX_DW  = 32;
    parameter int PWX_BEW = PWX_DW / 8;
    parameter int PWX_CW  = 6;

    typedef enum logic [1:0] {
        CMD_MEM_RD = 2'd0,
        CMD_MEM_WR = 2'd1,
        CMD_CFG_RD = 2'd2,
        CMD_CFG_WR = 2'd3
    } pwx_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } pwx_state_e;

    typedef struct packed {
        pwx_cmd_e              cmd;
        logic [PWX_AW-1:0]     addr;
        logic [PWX_BEW-1:0]    be;
    } pwx_desc_t;

endpackage

// File: rtl/pwx_ctrl.sv
// Module: control register and bus reset pin driver.
// Holds cycle select (bit 1), upper address field (bits 3:2) and reset pin
// mode (bits 5:4). Bit 0 is reserved and reads zero. Assumes the writer
// presents a full value on each strobe.
module pwx_ctrl #(
    parameter int CW = pwx_pkg::PWX_CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] q,
    output logic          cfg_sel,
    output logic [1:0]    upper,
    output logic          pin_oe,
    output logic          pin_out
);

    localparam int SEL_BIT = 1;
    localparam int UP_LO   = 2;
    localparam int MD_LO   = 4;

    logic [CW-1:0] reg_q;

    // Purpose: store the control value, reserved bit forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else if (we) begin
            reg_q <= {wdata[CW-1:1], 1'b0};
        end
    end

    // Purpose: split fields and decode the reset pin mode (11 acts as 00).
    always_comb begin
        q       = reg_q;
        cfg_sel = reg_q[SEL_BIT];
        upper   = reg_q[UP_LO+1:UP_LO];
        unique case (reg_q[MD_LO+1:MD_LO])
            2'b01:   begin pin_oe = 1'b1; pin_out = 1'b0; end
            2'b10:   begin pin_oe = 1'b1; pin_out = 1'b1; end
            default: begin pin_oe = 1'b0; pin_out = 1'b0; end
        endcase
    end

    AST_RST_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe |-> (pin_out == q[MD_LO+1])); // R8
    AST_RST_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (q[MD_LO+1:MD_LO] == 2'b11) |-> !pin_oe); // R8
    AST_RSV_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we) |=> (q[0] == 1'b0)); // R9

endmodule

// File: rtl/pwx_decode.sv
// Module: combinational window decoder.
// Decides whether a host request becomes a bus cycle and builds its
// descriptor. Assumes address bits 31:30 tag the window and the
// configuration limit is a power of two given as a bit index.
module pwx_decode #(
    parameter int         AW        = pwx_pkg::PWX_AW,
    parameter int         BEW       = pwx_pkg::PWX_BEW,
    parameter logic [1:0] WIN_TAG   = 2'b10,
    parameter int         CFG_LIMIT = 20
) (
    input  logic               write,
    input  logic [AW-1:0]      addr,
    input  logic [1:0]         size,
    input  logic               cfg_sel,
    input  logic [1:0]         upper,
    output logic               go,
    output pwx_pkg::pwx_desc_t desc
);
    import pwx_pkg::*;

    localparam int LW  = $clog2(BEW) + 1;
    localparam int OFW = AW - 2;

    logic          in_win;
    logic          size_ok;
    logic          aligned;
    logic          cfg_ok;
    logic [LW-1:0] nbytes;
    logic [LW-1:0] lo;
    logic [BEW-1:0] be_raw;

    // Purpose: translate the size code into a byte count.
    always_comb begin
        unique case (size)
            2'd0:    nbytes = LW'(1);
            2'd1:    nbytes = LW'(2);
            2'd2:    nbytes = LW'(4);
            default: nbytes = LW'(0);
        endcase
    end

    assign lo = LW'(addr[1:0]);

    // One enable per lane: set when the lane lies in [lo, lo + nbytes).
    for (genvar i = 0; i < BEW; i++) begin : g_lane
        assign be_raw[i] = (LW'(i) >= lo) && (LW'(i) < (lo + nbytes));
    end

    // Purpose: qualify the request and assemble the descriptor.
    always_comb begin
        in_win  = (addr[AW-1:AW-2] == WIN_TAG);
        size_ok = (nbytes != '0);
        aligned = ((lo & (nbytes - LW'(1))) == '0);
        cfg_ok  = !cfg_sel || (addr[OFW-1:CFG_LIMIT] == '0);
        go      = in_win && size_ok && aligned && cfg_ok;
        desc.addr = {upper, addr[OFW-1:0]};
        desc.be   = be_raw;
        unique case ({cfg_sel, write})
            2'b00:   desc.cmd = CMD_MEM_RD;
            2'b01:   desc.cmd = CMD_MEM_WR;
            2'b10:   desc.cmd = CMD_CFG_RD;
            default: desc.cmd = CMD_CFG_WR;
        endcase
    end

endmodule

// File: rtl/pwx_xact.sv
// Module: single-outstanding transaction sequencer.
// Accepts one host request, issues its descriptor, waits for the bus
// response and completes the host side. Assumes the bus side returns
// exactly one response per accepted descriptor.
module pwx_xact #(
    parameter int DW  = pwx_pkg::PWX_DW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               h_valid,
    output logic               h_ready,
    input  logic               h_write,
    input  logic [DW-1:0]      h_wdata,
    input  logic               go,
    input  pwx_pkg::pwx_desc_t desc_in,
    output logic               h_done,
    output logic               h_skip,
    output logic [DW-1:0]      h_rdata,
    output logic               p_req_valid,
    input  logic               p_req_ready,
    output pwx_pkg::pwx_desc_t desc_out,
    output logic [DW-1:0]      p_wdata,
    input  logic               p_rsp_valid,
    input  logic               p_rsp_abort,
    input  logic [DW-1:0]      p_rsp_data,
    output logic               irq_abort
);
    import pwx_pkg::*;

    pwx_state_e state;
    logic       wr_q;

    // Purpose: advance the transaction state and capture results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            desc_out  <= '0;
            p_wdata   <= '0;
            wr_q      <= 1'b0;
            h_skip    <= 1'b0;
            h_rdata   <= '0;
            irq_abort <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    irq_abort <= 1'b0;
                    if (h_valid) begin
                        if (go) begin
                            desc_out <= desc_in;
                            p_wdata  <= h_wdata;
                            wr_q     <= h_write;
                            state    <= ST_REQ;
                        end else begin
                            h_skip  <= 1'b1;
                            h_rdata <= '1;
                            state   <= ST_DONE;
                        end
                    end
                end
                ST_REQ: begin
                    if (p_req_ready) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (p_rsp_valid) begin
                        h_skip    <= 1'b0;
                        h_rdata   <= (p_rsp_abort || wr_q) ? '1 : p_rsp_data;
                        irq_abort <= p_rsp_abort;
                        state     <= ST_DONE;
                    end
                end
                default: begin
                    irq_abort <= 1'b0;
                    state     <= ST_IDLE;
                end
            endcase
        end
    end

    // Purpose: decode handshake strobes from the state.
    always_comb begin
        h_ready     = (state == ST_IDLE);
        p_req_valid = (state == ST_REQ);
        h_done      = (state == ST_DONE);
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (p_req_valid && !p_req_ready) |=> (p_req_valid && $stable(desc_out) && $stable(p_wdata))); // R10
    AST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        p_req_valid |-> !h_ready); // R10
    AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_abort |-> (h_done && !h_skip)); // R7
    AST_ABORT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_abort |=> !irq_abort); // R7
    AST_SKIP_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (h_done && h_skip) |-> (h_rdata == '1)); // R1

endmodule

// File: rtl/pci_win_xlat.sv
// Module: top of the host-to-PCI window translator.
// Ties the control register, the window decoder and the transaction
// sequencer together. Assumes one host request in flight at a time.
module pci_win_xlat #(
    parameter int         AW        = pwx_pkg::PWX_AW,
    parameter int         DW        = pwx_pkg::PWX_DW,
    parameter int         BEW       = pwx_pkg::PWX_BEW,
    parameter int         CW        = pwx_pkg::PWX_CW,
    parameter logic [1:0] WIN_TAG   = 2'b10,
    parameter int         CFG_LIMIT = 20
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ctl_we,
    input  logic [CW-1:0]  ctl_wdata,
    output logic [CW-1:0]  ctl_q,
    output logic           rst_pin_oe,
    output logic           rst_pin_out,
    input  logic           h_valid,
    output logic           h_ready,
    input  logic           h_write,
    input  logic [AW-1:0]  h_addr,
    input  logic [1:0]     h_size,
    input  logic [DW-1:0]  h_wdata,
    output logic           h_done,
    output logic           h_skip,
    output logic [DW-1:0]  h_rdata,
    output logic           p_req_valid,
    input  logic           p_req_ready,
    output logic [1:0]     p_cmd,
    output logic [AW-1:0]  p_addr,
    output logic [BEW-1:0] p_be,
    output logic [DW-1:0]  p_wdata,
    input  logic           p_rsp_valid,
    input  logic           p_rsp_abort,
    input  logic [DW-1:0]  p_rsp_data,
    output logic           irq_abort
);
    import pwx_pkg::*;

    logic      cfg_sel;
    logic [1:0] upper;
    logic      go;
    pwx_desc_t desc_new;
    pwx_desc_t desc_cur;

    pwx_ctrl #(.CW(CW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ctl_we),
        .wdata   (ctl_wdata),
        .q       (ctl_q),
        .cfg_sel (cfg_sel),
        .upper   (upper),
        .pin_oe  (rst_pin_oe),
        .pin_out (rst_pin_out)
    );

    pwx_decode #(
        .AW(AW), .BEW(BEW), .WIN_TAG(WIN_TAG), .CFG_LIMIT(CFG_LIMIT)
    ) u_dec (
        .write   (h_write),
        .addr    (h_addr),
        .size    (h_size),
        .cfg_sel (cfg_sel),
        .upper   (upper),
        .go      (go),
        .desc    (desc_new)
    );

    pwx_xact #(.DW(DW)) u_xact (
        .clk         (clk),
        .rst_n       (rst_n),
        .h_valid     (h_valid),
        .h_ready     (h_ready),
        .h_write     (h_write),
        .h_wdata     (h_wdata),
        .go          (go),
        .desc_in     (desc_new),
        .h_done      (h_done),
        .h_skip      (h_skip),
        .h_rdata     (h_rdata),
        .p_req_valid (p_req_valid),
        .p_req_ready (p_req_ready),
        .desc_out    (desc_cur),
        .p_wdata     (p_wdata),
        .p_rsp_valid (p_rsp_valid),
        .p_rsp_abort (p_rsp_abort),
        .p_rsp_data  (p_rsp_data),
        .irq_abort   (irq_abort)
    );

    // Purpose: flatten the registered descriptor onto the bus ports.
    always_comb begin
        p_cmd  = desc_cur.cmd;
        p_addr = desc_cur.addr;
        p_be   = desc_cur.be;
    end

    AST_WINDOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(p_req_valid) |-> ($past(h_addr[AW-1:AW-2]) == WIN_TAG)); // R1
    AST_CFG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (p_req_valid && p_cmd[1]) |-> (p_addr[AW-3:CFG_LIMIT] == '0)); // R4
    AST_BE_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        p_req_valid |-> (p_be != '0)); // R5
    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> (h_ready && !p_req_valid && (ctl_q == '0))); // R9

endmodule

// File: tb/pci_win_xlat_test.sv
// Bench: directed corners plus seeded random requests against a
// bench-side model of the window translator.
module pci_win_xlat_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ctl_we;
    logic [5:0]  ctl_wdata;
    logic [5:0]  ctl_q;
    logic        rst_pin_oe, rst_pin_out;
    logic        h_valid, h_ready, h_write;
    logic [31:0] h_addr, h_wdata, h_rdata;
    logic [1:0]  h_size;
    logic        h_done, h_skip;
    logic        p_req_valid, p_req_ready;
    logic [1:0]  p_cmd;
    logic [31:0] p_addr, p_wdata, p_rsp_data;
    logic [3:0]  p_be;
    logic        p_rsp_valid, p_rsp_abort;
    logic        irq_abort;

    int checks = 0;
    int fails  = 0;
    logic [5:0] ctl_model = '0;
    bit finished = 0;

    always #4 clk = ~clk;

    pci_win_xlat uut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_q(ctl_q), .rst_pin_oe(rst_pin_oe), .rst_pin_out(rst_pin_out),
        .h_valid(h_valid), .h_ready(h_ready), .h_write(h_write),
        .h_addr(h_addr), .h_size(h_size), .h_wdata(h_wdata),
        .h_done(h_done), .h_skip(h_skip), .h_rdata(h_rdata),
        .p_req_valid(p_req_valid), .p_req_ready(p_req_ready),
        .p_cmd(p_cmd), .p_addr(p_addr), .p_be(p_be), .p_wdata(p_wdata),
        .p_rsp_valid(p_rsp_valid), .p_rsp_abort(p_rsp_abort),
        .p_rsp_data(p_rsp_data), .irq_abort(irq_abort)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Model: does the request become a bus cycle (R1, R4, R5)?
    function automatic bit m_go(input logic [31:0] a, input logic [1:0] s);
        bit al;
        al = (s == 2'd0) || (s == 2'd1 && a[0] == 1'b0) || (s == 2'd2 && a[1:0] == 2'b00);
        return (a[31:30] == 2'b10) && al && (!ctl_model[1] || a[29:20] == 10'd0);
    endfunction

    // Model: byte enables (R5).
    function automatic logic [3:0] m_be(input logic [31:0] a, input logic [1:0] s);
        case (s)
            2'd0:    return 4'b0001 << a[1:0];
            2'd1:    return 4'b0011 << a[1:0];
            default: return 4'b1111;
        endcase
    endfunction

    task automatic ctl_write(input logic [5:0] v);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
        ctl_model = {v[5:1], 1'b0};
    endtask

    task automatic check_pin(input string tag);
        logic oe_e, out_e;
        oe_e  = (ctl_model[5:4] == 2'b01) || (ctl_model[5:4] == 2'b10);
        out_e = (ctl_model[5:4] == 2'b10);
        chk(ctl_q == ctl_model, "R8", {tag, " ctl_q"}, 32'(ctl_q), 32'(ctl_model));
        chk(rst_pin_oe == oe_e, "R8", {tag, " pin oe"}, 32'(rst_pin_oe), 32'(oe_e));
        chk(rst_pin_out == out_e, "R8", {tag, " pin level"}, 32'(rst_pin_out), 32'(out_e));
    endtask

    // One host request with a scripted bus response; optional stall and a
    // control write issued while the descriptor waits (R11).
    task automatic xact(input bit wr, input logic [31:0] a, input logic [1:0] s,
                        input logic [31:0] wd, input logic [31:0] rd,
                        input bit abort, input int stall, input bit poke_ctl);
        bit g;
        logic [1:0]  cmd_e;
        logic [31:0] addr_e;
        logic [3:0]  be_e;
        logic [31:0] rdata_e;
        g      = m_go(a, s);
        cmd_e  = {ctl_model[1], wr};
        addr_e = {ctl_model[3:2], a[29:0]};
        be_e   = m_be(a, s);
        @(negedge clk);
        chk(h_ready == 1'b1, "R10", "ready before request", 32'(h_ready), 32'd1);
        h_valid = 1'b1; h_write = wr; h_addr = a; h_size = s; h_wdata = wd;
        @(negedge clk);
        h_valid = 1'b0;
        chk(h_ready == 1'b0, "R10", "ready while busy", 32'(h_ready), 32'd0);
        if (!g) begin
            chk(h_done && h_skip, "R1", "skip completion", {30'd0, h_done, h_skip}, 32'd3);
            chk(h_rdata == 32'hFFFFFFFF, "R1", "skip data", h_rdata, 32'hFFFFFFFF);
            chk(p_req_valid == 1'b0, "R4", "no bus request", 32'(p_req_valid), 32'd0);
            chk(irq_abort == 1'b0, "R7", "no abort on skip", 32'(irq_abort), 32'd0);
        end else begin
            chk(p_req_valid == 1'b1, "R1", "request issued", 32'(p_req_valid), 32'd1);
            chk(p_cmd == cmd_e, "R3", "command code", 32'(p_cmd), 32'(cmd_e));
            chk(p_addr == addr_e, "R2", "bus address", p_addr, addr_e);
            chk(p_be == be_e, "R5", "byte enables", 32'(p_be), 32'(be_e));
            if (wr) chk(p_wdata == wd, "R6", "write data", p_wdata, wd);
            if (poke_ctl) begin
                ctl_we = 1'b1; ctl_wdata = 6'b001110;
            end
            for (int k = 0; k < stall; k++) begin
                @(negedge clk);
                ctl_we = 1'b0;
                chk(p_req_valid && p_addr == addr_e && p_cmd == cmd_e && p_be == be_e,
                    poke_ctl ? "R11" : "R10", "descriptor held", p_addr, addr_e);
            end
            if (poke_ctl) ctl_model = 6'b001110;
            p_req_ready = 1'b1;
            @(negedge clk);
            ctl_we = 1'b0;
            p_req_ready = 1'b0;
            p_rsp_valid = 1'b1; p_rsp_abort = abort; p_rsp_data = rd;
            @(negedge clk);
            p_rsp_valid = 1'b0; p_rsp_abort = 1'b0;
            rdata_e = abort ? 32'hFFFFFFFF : rd;
            chk(h_done && !h_skip, "R6", "bus completion", {30'd0, h_done, h_skip}, 32'd2);
            if (!wr || abort)
                chk(h_rdata == rdata_e, abort ? "R7" : "R6", "read data", h_rdata, rdata_e);
            chk(irq_abort == abort, "R7", "abort pulse", 32'(irq_abort), 32'(abort));
        end
        @(negedge clk);
        chk(!h_done && !irq_abort && h_ready, "R7", "completion ends",
            {29'd0, h_done, irq_abort, h_ready}, 32'd1);
    endtask

    initial begin
        int dummy;
        dummy = $urandom(32'd20240611);
        rst_n = 1'b0; ctl_we = 1'b0; ctl_wdata = '0;
        h_valid = 1'b0; h_write = 1'b0; h_addr = '0; h_size = '0; h_wdata = '0;
        p_req_ready = 1'b0; p_rsp_valid = 1'b0; p_rsp_abort = 1'b0; p_rsp_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(ctl_q == 6'd0, "R9", "ctl after reset", 32'(ctl_q), 32'd0);
        chk(!rst_pin_oe, "R9", "pin released", 32'(rst_pin_oe), 32'd0);
        chk(h_ready && !p_req_valid, "R9", "idle handshake", {30'd0, h_ready, p_req_valid}, 32'd2);

        // R1: window edges in memory mode
        xact(1'b0, 32'h7FFF_FFFC, 2'd2, 0, 32'h1111_2222, 1'b0, 0, 1'b0);
        xact(1'b0, 32'h8000_0000, 2'd2, 0, 32'hCAFE_0001, 1'b0, 0, 1'b0);
        xact(1'b1, 32'hBFFF_FFFC, 2'd2, 32'hA5A5_5A5A, 0, 1'b0, 0, 1'b0);
        xact(1'b0, 32'hC000_0000, 2'd2, 0, 0, 1'b0, 0, 1'b0);
        // R5: size and alignment corners
        xact(1'b0, 32'h8000_0003, 2'd0, 0, 32'h0000_00AB, 1'b0, 0, 1'b0);
        xact(1'b1, 32'h8000_0002, 2'd1, 32'h1234_0000, 0, 1'b0, 0, 1'b0);
        xact(1'b0, 32'h8000_0001, 2'd1, 0, 0, 1'b0, 0, 1'b0);
        xact(1'b0, 32'h8000_0002, 2'd2, 0, 0, 1'b0, 0, 1'b0);
        xact(1'b0, 32'h8000_0000, 2'd3, 0, 0, 1'b0, 0, 1'b0);
        // R2, R3, R4: configuration mode with upper bits 11
        ctl_write(6'b001110);
        xact(1'b0, 32'h8000_2104, 2'd2, 0, 32'h0000_168C, 1'b0, 0, 1'b0);
        xact(1'b1, 32'h800F_FFFC, 2'd2, 32'h0000_0006, 0, 1'b0, 0, 1'b0);
        xact(1'b0, 32'h8010_0000, 2'd2, 0, 0, 1'b0, 0, 1'b0);
        // R7: aborts on read and write
        xact(1'b0, 32'h8001_0000, 2'd2, 0, 32'h0BAD_0BAD, 1'b1, 0, 1'b0);
        xact(1'b1, 32'h8001_0004, 2'd2, 32'h5555_AAAA, 0, 1'b1, 0, 1'b0);
        // R10: stalled request engine; R11: control write while pending
        ctl_write(6'b000100);
        xact(1'b0, 32'h9000_0010, 2'd2, 0, 32'h0F0F_0F0F, 1'b0, 3, 1'b0);
        xact(1'b1, 32'h9000_0020, 2'd0, 32'h0000_7700, 0, 1'b0, 2, 1'b1);
        // R8: every pin mode, including reserved 11
        for (int m = 0; m < 4; m++) begin
            ctl_write({2'(m), 4'b0000});
            @(negedge clk);
            check_pin("mode");
        end
        // Seeded random mix
        for (int n = 0; n < 300; n++) begin
            logic [31:0] a;
            logic [1:0]  top;
            if (($urandom % 16) == 0) ctl_write(6'($urandom));
            top = (($urandom % 4) == 0) ? 2'($urandom) : 2'b10;
            a = {top, 30'($urandom)};
            if (($urandom % 2) == 0) a[29:20] = 10'd0;
            xact(1'($urandom), a, 2'($urandom), $urandom, $urandom,
                 (($urandom % 8) == 0), int'($urandom % 3), 1'b0);
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog run did not finish actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule